// File: doc/BRIEF.md
# Byte/Word ALU with Condition Flags

This block is the arithmetic and logic stage of a small integer datapath. Each cycle it takes a destination operand, a source operand, an operation code and a width select. It returns a result at 8 or 16 bits, computed without a clock. It also holds a six-bit condition flag register that updates on the next clock edge. Carry-using operations (add-with-carry, subtract-with-borrow, rotate-through-carry) read their carry input from that flag register. An operation issued in the cycle right after a carry-producing one therefore sees the fresh carry.

Every operation has its own flag update rule. A per-operation mask decides which flag bits are written and which keep their old value. The mask is also given on a port so that a surrounding flag file can follow the same rule. Compare and test produce flags only. Their result is marked as not to be written back. The register file and operand fetch sit outside this block.

Top module: `alu_flags_unit`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, CMP=4, INC=5, DEC=6, NEG=7, AND=8, OR=9, XOR=10, TEST=11, NOT=12, SHL=13, SHR=14, SAR=15, ROL=16, ROR=17, RCL=18, RCR=19. ADD computes a+b, and ADC computes a+b+CF using the registered carry. CF is the carry out of the selected width. AF is the carry out of bit 3. OF is signed overflow at the selected width.
- R2: SUB computes a-b, SBB computes a-b-CF, and CMP computes a-b. CF is set when the unsigned subtrahend (plus borrow) exceeds the minuend, and AF is the borrow out of bit 3. NEG computes 0-a. For NEG, CF is set when a is nonzero and OF is set only for the most negative value (80h byte, 8000h word).
- R3: INC (a+1) and DEC (a-1) update PF, AF, ZF, SF and OF but keep CF. For example, incrementing FFh in byte mode gives 00h and CF stays as it was.
- R4: AND, OR and XOR clear CF and OF, update PF, ZF and SF, and keep AF. NOT gives the one's complement and changes no flag.
- R5: CMP and TEST update their flags as SUB and AND would, but hold result_we low. Every other valid operation raises result_we in the same cycle.
- R6: Single-bit shifts update CF, PF, ZF, SF and OF. SHL fills the LSB with 0, sends the MSB to CF and sets OF = new MSB xor CF. SHR fills the MSB with 0, sends the LSB to CF and sets OF = old MSB. SAR keeps the sign bit, sends the LSB to CF and clears OF.
- R7: Rotates change only CF and OF. ROL and ROR copy the outgoing bit into both the opposite end and CF. RCL shifts the MSB into CF and the old CF into the LSB, and RCR does the mirror of this. For ROL and RCL, OF = new MSB xor CF. For ROR and RCR, OF = xor of the two top result bits.
- R8: With wide=0 the operation uses bits 7:0 of both operands, and result bits 15:8 read 0. SF is the top bit at the selected width. ZF is set when the result at that width is zero. PF is set when result bits 7:0 hold an even number of ones.
- R9: Flag layout is bit0 CF, bit1 PF, bit2 AF, bit3 ZF, bit4 SF, bit5 OF. After reset the flags are 0. Flags change only at a clock edge with op_valid high, and only in the bits of flag_mask. flag_mask and result_we are 0 when op_valid is low. Codes 20 to 31 are accepted but write no flag and no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select (encoding in R1) |
| wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| dst_a | input | 16 | Destination / first operand |
| src_b | input | 16 | Source / second operand |
| result | output | 16 | Combinational result, zero-extended in byte mode |
| result_we | output | 1 | Result should be written back |
| flag_mask | output | 6 | Flag bits this operation writes |
| flags_q | output | 6 | Registered condition flags |

## Verification
The critical overlap is a carry-consuming operation in the cycle right after one that writes the carry. In that cycle the carry input is read from the register just written at that edge. INC/DEC and rotates landing in that same cycle must also merge masked and kept flag bits at the same edge. The bench provokes both with back-to-back pairs: ADC after a carrying ADD, RCL after a flag-setting SUB, and INC of FFh right after a carry was set. It also interleaves long runs of pseudo-random operations with no idle cycles between them. A scoreboard model predicts each result in its issue cycle and the merged flag word one edge later, and compares them at the ports.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBB  = 5'd3,
      OP_CMP  = 5'd4,
      OP_INC  = 5'd5,
      OP_DEC  = 5'd6,
      OP_NEG  = 5'd7,
      OP_AND  = 5'd8,
      OP_OR   = 5'd9,
      OP_XOR  = 5'd10,
      OP_TEST = 5'd11,
      OP_NOT  = 5'd12,
      OP_SHL  = 5'd13,
      OP_SHR  = 5'd14,
      OP_SAR  = 5'd15,
      OP_ROL  = 5'd16,
      OP_ROR  = 5'd17,
      OP_RCL  = 5'd18,
      OP_RCR  = 5'd19
   } alu_op_e;

   localparam int FLAG_N = 6;
   localparam int FL_CF  = 0;
   localparam int FL_PF  = 1;
   localparam int FL_AF  = 2;
   localparam int FL_ZF  = 3;
   localparam int FL_SF  = 4;
   localparam int FL_OF  = 5;

   localparam logic [FLAG_N-1:0] UPD_NONE  = 6'b000000;
   localparam logic [FLAG_N-1:0] UPD_ALL   = 6'b111111;
   localparam logic [FLAG_N-1:0] UPD_NOCF  = 6'b111110;
   localparam logic [FLAG_N-1:0] UPD_LOGIC = 6'b111011;
   localparam logic [FLAG_N-1:0] UPD_ROT   = 6'b100001;

   typedef enum logic {X_OPA, X_ZERO} xsel_e;
   typedef enum logic [1:0] {Y_OPB, Y_ONE, Y_OPA} ysel_e;

   typedef struct packed {
      logic              is_sub;
      logic              use_cf;
      xsel_e             xsel;
      ysel_e             ysel;
      logic              bit_unit;
      logic [FLAG_N-1:0] upd;
      logic              wb;
   } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
`timescale 1ns/1ps
module alu_decode
   import alu_pkg::*;
(
   input  logic [4:0] op,
   output alu_ctl_t   ctl
);

   always_comb begin
      ctl          = '0;
      ctl.xsel     = X_OPA;
      ctl.ysel     = Y_OPB;
      ctl.upd      = UPD_NONE;
      case (op)
         OP_ADD: begin
            ctl.upd = UPD_ALL;
            ctl.wb  = 1'b1;
         end
         OP_ADC: begin
            ctl.use_cf = 1'b1;
            ctl.upd    = UPD_ALL;
            ctl.wb     = 1'b1;
         end
         OP_SUB: begin
            ctl.is_sub = 1'b1;
            ctl.upd    = UPD_ALL;
            ctl.wb     = 1'b1;
         end
         OP_SBB: begin
            ctl.is_sub = 1'b1;
            ctl.use_cf = 1'b1;
            ctl.upd    = UPD_ALL;
            ctl.wb     = 1'b1;
         end
         OP_CMP: begin
            ctl.is_sub = 1'b1;
            ctl.upd    = UPD_ALL;
         end
         OP_INC: begin
            ctl.ysel = Y_ONE;
            ctl.upd  = UPD_NOCF;
            ctl.wb   = 1'b1;
         end
         OP_DEC: begin
            ctl.is_sub = 1'b1;
            ctl.ysel   = Y_ONE;
            ctl.upd    = UPD_NOCF;
            ctl.wb     = 1'b1;
         end
         OP_NEG: begin
            ctl.is_sub = 1'b1;
            ctl.xsel   = X_ZERO;
            ctl.ysel   = Y_OPA;
            ctl.upd    = UPD_ALL;
            ctl.wb     = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            ctl.bit_unit = 1'b1;
            ctl.upd      = UPD_LOGIC;
            ctl.wb       = 1'b1;
         end
         OP_TEST: begin
            ctl.bit_unit = 1'b1;
            ctl.upd      = UPD_LOGIC;
         end
         OP_NOT: begin
            ctl.bit_unit = 1'b1;
            ctl.wb       = 1'b1;
         end
         OP_SHL, OP_SHR, OP_SAR: begin
            ctl.bit_unit = 1'b1;
            ctl.upd      = UPD_LOGIC;
            ctl.wb       = 1'b1;
         end
         OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
            ctl.bit_unit = 1'b1;
            ctl.use_cf   = 1'b1;
            ctl.upd      = UPD_ROT;
            ctl.wb       = 1'b1;
         end
         default: begin
            ctl.upd = UPD_NONE;
            ctl.wb  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              wide,
   input  logic              is_sub,
   input  logic              cin,
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   output logic [DATA_W-1:0] sum,
   output logic              co,
   output logic              ac,
   output logic              ov
);

   localparam int XW = DATA_W + 1;
   localparam logic [DATA_W-1:0] FULL_M = '1;
   localparam logic [DATA_W-1:0] NARR_M = DATA_W'((64'd1 << NARROW_W) - 64'd1);

   logic [DATA_W-1:0] wm, xm, ym;
   logic [XW-1:0]     ext;
   logic              xs, ys, rs;

   assign wm = wide ? FULL_M : NARR_M;
   assign xm = x & wm;
   assign ym = y & wm;

   always_comb begin
      if (is_sub)
         ext = {1'b0, xm} - {1'b0, ym} - XW'(cin);
      else
         ext = {1'b0, xm} + {1'b0, ym} + XW'(cin);
   end

   assign sum = ext[DATA_W-1:0] & wm;
   // zero-extended operands: a borrow floods every upper bit, so one tap serves both
   assign co  = wide ? ext[DATA_W] : ext[NARROW_W];
   assign ac  = xm[4] ^ ym[4] ^ ext[4];

   assign xs  = wide ? xm[DATA_W-1] : xm[NARROW_W-1];
   assign ys  = wide ? ym[DATA_W-1] : ym[NARROW_W-1];
   assign rs  = wide ? sum[DATA_W-1] : sum[NARROW_W-1];
   assign ov  = is_sub ? ((xs != ys) && (rs != xs)) : ((xs == ys) && (rs != xs));

endmodule

// File: rtl/alu_bitops.sv
`timescale 1ns/1ps
module alu_bitops
   import alu_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic [4:0]        op,
   input  logic              wide,
   input  logic              cin,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              co,
   output logic              ov
);

   localparam logic [DATA_W-1:0] FULL_M = '1;
   localparam logic [DATA_W-1:0] NARR_M = DATA_W'((64'd1 << NARROW_W) - 64'd1);
   localparam logic [DATA_W-1:0] TOP_W  = DATA_W'(1) << (DATA_W - 1);
   localparam logic [DATA_W-1:0] TOP_N  = DATA_W'(1) << (NARROW_W - 1);

   logic [DATA_W-1:0] wm, tb, am, bm, shl, shr;
   logic              a_top, a_low, r_top, r_next;

   assign wm    = wide ? FULL_M : NARR_M;
   assign tb    = wide ? TOP_W : TOP_N;
   assign am    = a & wm;
   assign bm    = b & wm;
   assign a_top = |(am & tb);
   assign a_low = am[0];
   assign shl   = (am << 1) & wm;
   assign shr   = am >> 1;

   always_comb begin
      res = '0;
      co  = 1'b0;
      case (op)
         OP_AND, OP_TEST: res = am & bm;
         OP_OR:           res = am | bm;
         OP_XOR:          res = am ^ bm;
         OP_NOT:          res = ~am & wm;
         OP_SHL: begin res = shl;                        co = a_top; end
         OP_SHR: begin res = shr;                        co = a_low; end
         OP_SAR: begin res = shr | (a_top ? tb : '0);   co = a_low; end
         OP_ROL: begin res = shl | DATA_W'(a_top);      co = a_top; end
         OP_ROR: begin res = shr | (a_low ? tb : '0);   co = a_low; end
         OP_RCL: begin res = shl | DATA_W'(cin);        co = a_top; end
         OP_RCR: begin res = shr | (cin ? tb : '0);     co = a_low; end
         default: res = '0;
      endcase
      r_top  = |(res & tb);
      r_next = |(res & (tb >> 1));
      case (op)
         OP_SHL, OP_ROL, OP_RCL: ov = r_top ^ co;
         OP_SHR:                 ov = a_top;
         OP_ROR, OP_RCR:         ov = r_top ^ r_next;
         default:                ov = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg #(
   parameter int FLAG_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [FLAG_W-1:0] upd,
   input  logic [FLAG_W-1:0] nxt,
   output logic [FLAG_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= (q & ~upd) | (nxt & upd);
   end

endmodule

// File: rtl/alu_flags_unit.sv
`timescale 1ns/1ps
module alu_flags_unit
   import alu_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int PARITY_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [4:0]        op_code,
   input  logic              wide,
   input  logic [DATA_W-1:0] dst_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] result,
   output logic              result_we,
   output logic [FLAG_N-1:0] flag_mask,
   output logic [FLAG_N-1:0] flags_q
);

   generate
      if (NARROW_W < PARITY_W || NARROW_W >= DATA_W) begin : g_bad_width
         $error("alu_flags_unit: need PARITY_W <= NARROW_W < DATA_W");
      end
      if (NARROW_W < 5) begin : g_bad_nibble
         $error("alu_flags_unit: auxiliary carry needs NARROW_W >= 5");
      end
   endgenerate

   alu_ctl_t          ctl;
   logic [DATA_W-1:0] x_in, y_in, s_res, b_res;
   logic              s_co, s_ac, s_ov, b_co, b_ov, cin;
   logic [FLAG_N-1:0] nxt_flags;
   logic [PARITY_W-1:0] par_chain;
   logic              zf, sf, pf;

   alu_decode u_dec (
      .op  (op_code),
      .ctl (ctl)
   );

   assign cin  = ctl.use_cf & flags_q[FL_CF];
   assign x_in = (ctl.xsel == X_ZERO) ? '0 : dst_a;

   always_comb begin
      case (ctl.ysel)
         Y_ONE:   y_in = DATA_W'(1);
         Y_OPA:   y_in = dst_a;
         default: y_in = src_b;
      endcase
   end

   alu_addsub #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_arith (
      .wide   (wide),
      .is_sub (ctl.is_sub),
      .cin    (cin),
      .x      (x_in),
      .y      (y_in),
      .sum    (s_res),
      .co     (s_co),
      .ac     (s_ac),
      .ov     (s_ov)
   );

   alu_bitops #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_bits (
      .op   (op_code),
      .wide (wide),
      .cin  (cin),
      .a    (dst_a),
      .b    (src_b),
      .res  (b_res),
      .co   (b_co),
      .ov   (b_ov)
   );

   assign result = ctl.bit_unit ? b_res : s_res;

   // parity over the low byte: ripple of xor taps, one per bit
   assign par_chain[0] = result[0];
   generate
      for (genvar i = 1; i < PARITY_W; i++) begin : g_par
         assign par_chain[i] = par_chain[i-1] ^ result[i];
      end
   endgenerate

   assign pf = ~par_chain[PARITY_W-1];
   assign zf = ~|result;
   assign sf = wide ? result[DATA_W-1] : result[NARROW_W-1];

   always_comb begin
      nxt_flags        = '0;
      nxt_flags[FL_CF] = ctl.bit_unit ? b_co : s_co;
      nxt_flags[FL_PF] = pf;
      nxt_flags[FL_AF] = s_ac;
      nxt_flags[FL_ZF] = zf;
      nxt_flags[FL_SF] = sf;
      nxt_flags[FL_OF] = ctl.bit_unit ? b_ov : s_ov;
   end

   assign flag_mask = op_valid ? ctl.upd : '0;
   assign result_we = op_valid & ctl.wb;

   alu_flag_reg #(.FLAG_W(FLAG_N)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (op_valid),
      .upd   (ctl.upd),
      .nxt   (nxt_flags),
      .q     (flags_q)
   );

endmodule

// File: rtl/alu_flags_chk.sv
`timescale 1ns/1ps
module alu_flags_chk
   import alu_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [4:0]        op_code,
   input logic              wide,
   input logic [DATA_W-1:0] result,
   input logic              result_we,
   input logic [FLAG_N-1:0] flag_mask,
   input logic [FLAG_N-1:0] flags_q
);

   a_r3_inc_dec_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_code == OP_INC || op_code == OP_DEC)
      |=> flags_q[FL_CF] == $past(flags_q[FL_CF]));

   a_r4_logic_clears_cf_of: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR || op_code == OP_TEST)
      |=> !flags_q[FL_CF] && !flags_q[FL_OF]);

   a_r5_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_code == OP_CMP || op_code == OP_TEST) |-> !result_we);

   a_r7_rotate_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_code == OP_ROL || op_code == OP_ROR || op_code == OP_RCL || op_code == OP_RCR)
      |=> flags_q[FL_SF:FL_PF] == $past(flags_q[FL_SF:FL_PF]));

   a_r8_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |-> result[DATA_W-1:NARROW_W] == '0);

   a_r9_idle_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(flags_q));

   a_r9_idle_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> flag_mask == '0 && !result_we);

endmodule

bind alu_flags_unit alu_flags_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .wide      (wide),
   .result    (result),
   .result_we (result_we),
   .flag_mask (flag_mask),
   .flags_q   (flags_q)
);

// File: tb/alu_flags_unit_test.sv
`timescale 1ns/1ps
module alu_flags_unit_test;
   import alu_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_code = 5'd0;
   logic        wide = 1'b0;
   logic [15:0] dst_a = 16'h0, src_b = 16'h0;
   logic [15:0] result;
   logic        result_we;
   logic [5:0]  flag_mask, flags_q;

   typedef struct {
      logic [15:0] res;
      logic        we;
      logic [5:0]  mask;
      logic [5:0]  flags;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [5:0]  m_flags = 6'h0;
   int          n_checks = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   alu_flags_unit uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .wide(wide),
      .dst_a(dst_a), .src_b(src_b), .result(result), .result_we(result_we),
      .flag_mask(flag_mask), .flags_q(flags_q)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int sx(int v, int w);
      return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
   endfunction

   function automatic string tag_of(int op);
      case (op)
         0, 1:          return "R1";
         2, 3, 7:       return "R2";
         5, 6:          return "R3";
         8, 9, 10, 12:  return "R4";
         4, 11:         return "R5";
         13, 14, 15:    return "R6";
         16, 17, 18, 19: return "R7";
         default:       return "R9";
      endcase
   endfunction

   // reference from the written requirements; flag bits CF0 PF1 AF2 ZF3 SF4 OF5
   function automatic void model(input int op, input int a, input int b, input bit w,
                                 input logic [5:0] fin, output logic [15:0] r,
                                 output logic [5:0] m, output logic [5:0] fout, output logic we);
      int wd, full, top, am, bm, c, v, s, cc;
      int cf, af, of, zf, sf, pf;
      wd = w ? 16 : 8;
      full = (1 << wd) - 1;
      top = 1 << (wd - 1);
      am = a & full; bm = b & full; c = int'(fin[0]);
      v = 0; cf = 0; af = 0; of = 0; m = 6'h00; we = 1'b1;
      case (op)
         0, 1, 5: begin
            cc = (op == 1) ? c : 0;
            if (op == 5) bm = 1;
            s = am + bm + cc; v = s & full; cf = (s > full) ? 1 : 0;
            af = (((am & 15) + (bm & 15) + cc) > 15) ? 1 : 0;
            s = sx(am, wd) + sx(bm, wd) + cc;
            of = (s > top - 1 || s < -top) ? 1 : 0;
            m = (op == 5) ? 6'h3E : 6'h3F;
         end
         2, 3, 4, 6: begin
            cc = (op == 3) ? c : 0;
            if (op == 6) bm = 1;
            s = am - bm - cc; v = s & full; cf = (s < 0) ? 1 : 0;
            af = ((am & 15) < ((bm & 15) + cc)) ? 1 : 0;
            s = sx(am, wd) - sx(bm, wd) - cc;
            of = (s > top - 1 || s < -top) ? 1 : 0;
            m = (op == 6) ? 6'h3E : 6'h3F;
            we = (op != 4);
         end
         7: begin
            v = (0 - am) & full; cf = (am != 0) ? 1 : 0;
            af = ((am & 15) != 0) ? 1 : 0; of = (am == top) ? 1 : 0; m = 6'h3F;
         end
         8, 11: begin v = am & bm; m = 6'h3B; we = (op != 11); end
         9:  begin v = am | bm; m = 6'h3B; end
         10: begin v = am ^ bm; m = 6'h3B; end
         12: begin v = ~am & full; m = 6'h00; end
         13: begin
            v = (am << 1) & full; cf = ((am & top) != 0) ? 1 : 0;
            of = (((v & top) != 0) ? 1 : 0) ^ cf; m = 6'h3B;
         end
         14: begin v = am >> 1; cf = am & 1; of = ((am & top) != 0) ? 1 : 0; m = 6'h3B; end
         15: begin v = (am >> 1) | (am & top); cf = am & 1; of = 0; m = 6'h3B; end
         16, 18: begin
            cf = ((am & top) != 0) ? 1 : 0;
            v = ((am << 1) & full) | ((op == 16) ? cf : c);
            of = (((v & top) != 0) ? 1 : 0) ^ cf; m = 6'h21;
         end
         17, 19: begin
            cf = am & 1;
            v = (am >> 1) | ((((op == 17) ? cf : c) != 0) ? top : 0);
            of = (((v & top) != 0) ? 1 : 0) ^ (((v & (top >> 1)) != 0) ? 1 : 0); m = 6'h21;
         end
         default: begin v = 0; m = 6'h00; we = 1'b0; end
      endcase
      zf = (v == 0) ? 1 : 0;
      sf = ((v & top) != 0) ? 1 : 0;
      pf = ($countones(v & 255) % 2 == 0) ? 1 : 0;
      r = 16'(v);
      fout = (fin & ~m) | (6'({of[0], sf[0], zf[0], af[0], pf[0], cf[0]}) & m);
   endfunction

   task automatic issue(int op, int a, int b, bit w, string tag);
      exp_t it;
      logic [15:0] r; logic [5:0] m, f; logic we;
      @(posedge clk); #1;
      op_valid = 1'b1; op_code = 5'(op); wide = w; dst_a = 16'(a); src_b = 16'(b);
      model(op, a & 16'hFFFF, b & 16'hFFFF, w, m_flags, r, m, f, we);
      it.res = r; it.we = we; it.mask = m; it.flags = f;
      it.tag = (tag == "") ? tag_of(op) : tag;
      sb.push_back(it);
      m_flags = f;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      op_valid = 1'b0; op_code = 5'(OP_ADD); wide = 1'b1; dst_a = 16'hFFFF; src_b = 16'h0001;
   endtask

   // monitor: result side checked in the issue cycle, flag side one edge later
   initial begin : monitor
      logic [5:0] pend_flags;
      string      pend_tag;
      exp_t       it;
      pend_flags = 6'h00; pend_tag = "R9";
      wait (rst_n === 1'b1);
      while (!done) begin
         @(posedge clk); #6;
         chk(pend_tag, "flags_q", int'(flags_q), int'(pend_flags));
         if (op_valid) begin
            if (sb.size() == 0) begin
               chk("R9", "scoreboard empty", 1, 0);
            end else begin
               it = sb.pop_front();
               if (it.we) chk(it.tag, "result", int'(result), int'(it.res));
               chk(it.tag, "result_we", int'(result_we), int'(it.we));
               chk(it.tag, "flag_mask", int'(flag_mask), int'(it.mask));
               pend_flags = it.flags; pend_tag = it.tag;
            end
         end else begin
            chk("R9", "idle result_we", int'(result_we), 0);
            chk("R9", "idle flag_mask", int'(flag_mask), 0);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : driver
      int unsigned s;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      chk("R9", "reset flags_q", int'(flags_q), 0);
      chk("R9", "reset result_we", int'(result_we), 0);
      chk("R9", "reset flag_mask", int'(flag_mask), 0);

      issue(OP_ADD, 16'h0074, 16'h0020, 1'b0, "");
      issue(OP_ADD, 16'h00FF, 16'h0001, 1'b0, "");
      issue(OP_ADD, 16'h7FFF, 16'h0001, 1'b1, "");
      issue(OP_ADD, 16'hFFFF, 16'hFFFF, 1'b1, "");
      issue(OP_ADD, 16'h0080, 16'h0080, 1'b0, "R1");   // sets carry
      issue(OP_ADC, 16'h0001, 16'h0001, 1'b0, "R1");   // back-to-back carry use
      issue(OP_SUB, 16'h0010, 16'h0020, 1'b0, "");
      issue(OP_SBB, 16'h0005, 16'h0005, 1'b0, "R2");
      issue(OP_CMP, 16'h1234, 16'h1234, 1'b1, "R5");
      issue(OP_NEG, 16'h0080, 16'h0000, 1'b0, "R2");
      issue(OP_NEG, 16'h8000, 16'h0000, 1'b1, "R2");
      issue(OP_NEG, 16'h0000, 16'h0000, 1'b1, "R2");
      issue(OP_ADD, 16'h00FF, 16'h0001, 1'b0, "R3");   // CF=1
      issue(OP_INC, 16'h00FF, 16'h0000, 1'b0, "R3");   // CF stays 1
      issue(OP_SUB, 16'h0000, 16'h0000, 1'b1, "R3");   // CF=0
      issue(OP_DEC, 16'h0000, 16'h0000, 1'b0, "R3");   // CF stays 0
      issue(OP_INC, 16'h7FFF, 16'h0000, 1'b1, "R3");
      issue(OP_NEG, 16'h0080, 16'h0000, 1'b0, "R4");   // CF=1, OF=1
      issue(OP_AND, 16'h003A, 16'h000F, 1'b0, "R4");
      issue(OP_OR,  16'h003A, 16'h000F, 1'b0, "R4");
      issue(OP_XOR, 16'h3D69, 16'h00FF, 1'b1, "R4");
      issue(OP_TEST, 16'h0080, 16'h0080, 1'b0, "R5");
      issue(OP_NOT, 16'h3A10, 16'h0000, 1'b1, "R4");
      issue(OP_SHL, 16'h0081, 16'h0000, 1'b0, "R6");
      issue(OP_SHR, 16'h0001, 16'h0000, 1'b1, "R6");
      issue(OP_SAR, 16'h0080, 16'h0000, 1'b0, "R6");
      issue(OP_SAR, 16'h8001, 16'h0000, 1'b1, "R6");
      issue(OP_ROL, 16'h0080, 16'h0000, 1'b0, "R7");
      issue(OP_ROR, 16'h0001, 16'h0000, 1'b1, "R7");
      issue(OP_SUB, 16'h0000, 16'h0001, 1'b0, "R7");   // CF=1
      issue(OP_RCL, 16'h0040, 16'h0000, 1'b0, "R7");
      issue(OP_RCR, 16'h0002, 16'h0000, 1'b1, "R7");
      issue(OP_ADD, 16'hAB12, 16'hCD34, 1'b0, "R8");
      issue(OP_XOR, 16'hFF0F, 16'h12F0, 1'b0, "R8");
      issue(OP_SUB, 16'h9980, 16'h7780, 1'b0, "R8");
      idle(); idle();
      issue(25, 16'hFFFF, 16'hFFFF, 1'b1, "R9");
      issue(31, 16'h0000, 16'h0000, 1'b0, "R9");
      idle();

      s = 32'h1234_5678;
      for (int k = 0; k < 400; k++) begin
         int op, a, b;
         s ^= s << 13; s ^= s >> 17; s ^= s << 5;
         op = int'(s % 22);
         a = int'(s[15:0]);
         b = int'(s[31:16]);
         issue(op, a, b, s[7], "");
         if (s[20:18] == 3'd0) idle();
      end

      idle(); idle(); idle();
      #2;
      chk("R9", "scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule